// File: doc/BRIEF.md
# Adaptive Variable-Latency Hold Controller

This controller sits beside a bypassing array multiplier that runs on a clock shorter than its worst-case path. For each operand pair offered, it looks at the operand that steers the bypass logic. That is the multiplicand for column bypassing and the multiplier for row bypassing. It counts the zero bits in that operand, and a high zero count means the multiply can settle in a single cycle. Two judges run in parallel, a loose one and a strict one, and the one in force is picked by the aging status. When an operation needs two cycles, the controller lowers the operand-register enable for exactly one cycle, so the operands are held while the array finishes.

Shadow-latch error detectors report a late result one cycle after a single-cycle operation is captured. Each such report forces a one-cycle hold, so that the operation is re-executed over two cycles. The report is also counted by an aging monitor. The monitor counts issued operations in fixed windows and clears the error tally at the end of each window. If the tally within a window goes over a limit, the monitor sets the aged flag. From then on the strict judge is used, until a global reset.

The hold logic is a two-state machine. In state ST_OPEN the enable is high. In state ST_STALL the enable is low. The transition OPEN->STALL happens on a two-cycle issue or on a qualified error report. The transition STALL->OPEN happens in the following cycle. The transition STALL->STALL happens only when a qualified error report arrives while stalled. The transition OPEN->OPEN covers everything else.

Top module: `avl_hold_ctrl`

## Requirements
- R1: After reset, capture_en is 1 and aged is 0. The error tally and the operation count are zero.
- R2: While aged is 0, one_cycle is 1 exactly when the number of 0 bits across all W bits of operand is greater than N_ZERO (default 8).
- R3: While aged is 1, one_cycle is 1 exactly when the zero count is greater than N_ZERO+1 (default 9).
- R4: An issue is a cycle where op_valid and capture_en are both 1. An issue with one_cycle 0 makes capture_en 0 in the next cycle and 1 again in the cycle after that.
- R5: An issue with one_cycle 1, with no error report pending, leaves capture_en at 1 in the next cycle.
- R6: op_valid asserted while capture_en is 0 has no effect: capture_en returns to 1 after the single stall cycle.
- R7: err_flag asserted in the cycle right after an issue with one_cycle 1 makes capture_en 0 for exactly the next cycle, and the report counts toward the aging tally.
- R8: err_flag is ignored in any other cycle, whether after a two-cycle issue or with no preceding issue. It neither stalls nor counts.
- R9: aged becomes 1 in the cycle after a qualified error report takes the window's tally above ERR_LIMIT (default 2, so on the third report).
- R10: Issues are counted in windows of WINDOW operations (default 8). The issue that completes a window clears the error tally.
- R11: Once set, aged stays 1 regardless of later traffic until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A new operand pair is offered this cycle |
| operand | input | W | Bypass-steering operand examined for zero bits |
| err_flag | input | 1 | Timing-error report from the shadow-latch detectors |
| capture_en | output | 1 | Active-high enable of the operand input registers |
| one_cycle | output | 1 | 1 when the current operand is judged single-cycle |
| aged | output | 1 | Latched aging status; selects the strict judge |

## Verification
The bench probes operands whose zero count sits exactly at each threshold (8 and 9 zeros). An off-by-one judge would call the at-threshold operand single-cycle and let a slow multiply be captured early. It stalls two-cycle issues and offers new operands during the stall. A machine that re-entered the stall, or held for two cycles, would show capture_en low once too often. It places error reports on both sides of a window boundary. A tally that never clears would age the block after four spread-out errors, and a flag that is not sticky would drop back to the loose judge once a quiet window ends. Error reports after a two-cycle issue, or with no issue before them, must not stall or count.

// File: rtl/avl_pkg.sv
package avl_pkg;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_STALL = 1'b1
    } hold_state_e;

    localparam int unsigned NUM_JUDGES = 2;

endpackage

// File: rtl/zero_judge.sv
module zero_judge #(
    parameter int unsigned W     = 16,
    parameter int unsigned LIMIT = 8
) (
    input  logic [W-1:0] operand,
    output logic         fast
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [CW-1:0] zeros;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CW'(!operand[i]);
        end
    end

    assign fast = (int'(zeros) > int'(LIMIT));

endmodule

// File: rtl/wear_monitor.sv
module wear_monitor #(
    parameter int unsigned WINDOW    = 8,
    parameter int unsigned ERR_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic err_hit,
    output logic aged
);
    localparam int unsigned OCW  = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int unsigned ECW  = $clog2(WINDOW + 2);
    localparam logic [OCW-1:0] LAST_OP = OCW'(WINDOW - 1);
    localparam logic [ECW-1:0] ERR_MAX = {ECW{1'b1}};

    logic [OCW-1:0] op_cnt, op_cnt_nxt;
    logic [ECW-1:0] err_cnt, err_cnt_nxt;
    logic           wrap, aged_nxt;

    always_comb begin
        wrap       = issue && (op_cnt == LAST_OP);
        op_cnt_nxt = op_cnt;
        if (issue) begin
            op_cnt_nxt = wrap ? '0 : op_cnt + 1'b1;
        end
        if (wrap) begin
            err_cnt_nxt = ECW'(err_hit);
        end else if (err_hit && (err_cnt != ERR_MAX)) begin
            err_cnt_nxt = err_cnt + 1'b1;
        end else begin
            err_cnt_nxt = err_cnt;
        end
        aged_nxt = aged || (int'(err_cnt_nxt) > int'(ERR_LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_cnt  <= '0;
            err_cnt <= '0;
            aged    <= 1'b0;
        end else begin
            op_cnt  <= op_cnt_nxt;
            err_cnt <= err_cnt_nxt;
            aged    <= aged_nxt;
        end
    end

    assert_aged_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        aged |=> aged);

    assert_window_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(op_cnt) < int'(WINDOW));

    assert_quiet_no_age_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!aged && !err_hit) |=> !aged);

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import avl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic fast,
    input  logic err_flag,
    output logic capture_en,
    output logic issue,
    output logic err_hit
);
    hold_state_e state, state_nxt;
    logic        last_fast;

    assign issue   = op_valid && capture_en;
    assign err_hit = err_flag && last_fast;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN:  state_nxt = ((issue && !fast) || err_hit) ? ST_STALL : ST_OPEN;
            ST_STALL: state_nxt = err_hit ? ST_STALL : ST_OPEN;
            default:  state_nxt = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OPEN;
            last_fast <= 1'b0;
        end else begin
            state     <= state_nxt;
            last_fast <= issue && fast;
        end
    end

    always_comb begin
        capture_en = 1'b1;
        unique case (state)
            ST_OPEN:  capture_en = 1'b1;
            ST_STALL: capture_en = 1'b0;
            default:  capture_en = 1'b1;
        endcase
    end

    assert_slow_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !fast) |=> !capture_en);

    assert_stall_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !err_hit) |=> capture_en);

    assert_err_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |=> !capture_en);

    assert_fast_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && fast && !err_hit) |=> capture_en);

endmodule

// File: rtl/avl_hold_ctrl.sv
module avl_hold_ctrl
    import avl_pkg::*;
#(
    parameter int unsigned W         = 16,
    parameter int unsigned N_ZERO    = 8,
    parameter int unsigned WINDOW    = 8,
    parameter int unsigned ERR_LIMIT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [W-1:0] operand,
    input  logic         err_flag,
    output logic         capture_en,
    output logic         one_cycle,
    output logic         aged
);
    logic [NUM_JUDGES-1:0] judge_vec;
    logic                  issue, err_hit;

    for (genvar g = 0; g < NUM_JUDGES; g++) begin : g_judge
        zero_judge #(
            .W     (W),
            .LIMIT (N_ZERO + g)
        ) u_judge (
            .operand (operand),
            .fast    (judge_vec[g])
        );
    end

    assign one_cycle = aged ? judge_vec[1] : judge_vec[0];

    hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .fast       (one_cycle),
        .err_flag   (err_flag),
        .capture_en (capture_en),
        .issue      (issue),
        .err_hit    (err_hit)
    );

    wear_monitor #(
        .WINDOW    (WINDOW),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .err_hit (err_hit),
        .aged    (aged)
    );

    assert_judge_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        judge_vec[1] |-> judge_vec[0]);

endmodule

// File: tb/tb_avl_hold_ctrl.sv
module tb_avl_hold_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] operand = '0;
    logic        err_flag = 1'b0;
    logic        capture_en, one_cycle, aged;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    avl_hold_ctrl dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .operand(operand),
        .err_flag(err_flag), .capture_en(capture_en), .one_cycle(one_cycle), .aged(aged)
    );

    // {operand, expected one_cycle with loose judge}
    localparam logic [16:0] VECS [8] = '{
        {16'h0000, 1'b1}, {16'hFFFF, 1'b0}, {16'h00FF, 1'b0}, {16'h007F, 1'b1},
        {16'h01FF, 1'b0}, {16'h0F0F, 1'b0}, {16'h8001, 1'b1}, {16'h003F, 1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] op, input logic e);
        @(negedge clk);
        op_valid = v; operand = op; err_flag = e;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; op_valid = 0; err_flag = 0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // fast issue followed by an error report
    task automatic do_err();
        drive(1, 16'h0000, 0); check("R5", capture_en, 1'b1);
        drive(0, 16'h0000, 1); check("R5", capture_en, 1'b1);
        drive(0, 16'h0000, 0); check("R7", capture_en, 1'b0);
        drive(0, 16'h0000, 0); check("R7", capture_en, 1'b1);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        drive(0, 16'h0000, 0);
        check("R1", capture_en, 1'b1);
        check("R1", aged, 1'b0);

        // table walk, loose judge: R2, R4, R5
        for (int i = 0; i < 8; i++) begin
            drive(1, VECS[i][16:1], 0);
            #1 check("R2", one_cycle, VECS[i][0]);
            check("R4", capture_en, 1'b1);
            drive(0, 16'h0000, 0);
            check(VECS[i][0] ? "R5" : "R4", capture_en, VECS[i][0]);
            if (!VECS[i][0]) begin
                drive(0, 16'h0000, 0);
                check("R4", capture_en, 1'b1);
            end
        end

        // window clearing: 8 issues done, window restarts
        do_err(); do_err();
        for (int k = 0; k < 6; k++) drive(1, 16'h0000, 0);
        drive(0, 16'h0000, 0);
        do_err(); do_err();
        check("R10", aged, 1'b0);
        do_err();
        check("R9", aged, 1'b1);

        // strict judge
        drive(0, 16'h007F, 0); #1 check("R3", one_cycle, 1'b0);
        drive(0, 16'h003F, 0); #1 check("R3", one_cycle, 1'b1);
        drive(1, 16'h007F, 0);
        drive(0, 16'h0000, 0); check("R3", capture_en, 1'b0);
        drive(0, 16'h0000, 0); check("R3", capture_en, 1'b1);

        // sticky flag over a quiet stretch
        for (int k = 0; k < 10; k++) drive(1, 16'h0000, 0);
        drive(0, 16'h0000, 0);
        check("R11", aged, 1'b1);

        // error after a two-cycle issue is ignored
        drive(1, 16'h007F, 0);
        drive(0, 16'h0000, 1); check("R8", capture_en, 1'b0);
        drive(0, 16'h0000, 0); check("R8", capture_en, 1'b1);
        // error with no preceding issue is ignored
        drive(0, 16'h0000, 1);
        drive(0, 16'h0000, 0); check("R8", capture_en, 1'b1);

        // valid during stall is ignored
        drive(1, 16'hFFFF, 0);
        drive(1, 16'hFFFF, 0); check("R6", capture_en, 1'b0);
        drive(0, 16'h0000, 0); check("R6", capture_en, 1'b1);

        // reset clears the aged flag
        do_reset();
        drive(0, 16'h007F, 0);
        #1 check("R1", aged, 1'b0);
        check("R1", capture_en, 1'b1);
        check("R2", one_cycle, 1'b1);

        // ignored errors do not count: two real + one ignored must not age
        do_err(); do_err();
        drive(0, 16'h0000, 1);
        drive(0, 16'h0000, 0);
        check("R8", aged, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule